// File: doc/BRIEF.md
# Edge-Engine Control Register Slave

This block is the register front end of a frame-scan edge-detection engine. It sits on a 32-bit AHB-Lite bus as a slave and handles single transfers into a window of four word registers. Through these registers software gives the frame's starting memory address and a pixel-gradient threshold, commands the engine to start or stop, and reads back whether a scan is in progress or has finished.

Towards the engine the block drives a one-cycle start pulse and a one-cycle stop pulse. It receives a one-cycle completion pulse from the engine and holds it in a sticky flag until software clears it. The frame base and threshold are presented to the engine as steady outputs. Every transfer completes with an OKAY response and no wait states.

Word map, decoded on `haddr[3:2]` with `haddr[31:4]` required to be zero: index 0 (offset 0x0) command, index 1 (0x4) frame base, index 2 (0x8) threshold, index 3 (0xC) status.

Top module: `edge_ctrl_slave`

## Requirements
- R1: `hreadyout` is always 1 and `hresp` is always 0 (OKAY), so no transfer ever waits.
- R2: An address phase is taken only when `hsel`, `hready` and `htrans[1]` are all 1; IDLE (`htrans`=00) or BUSY (01) transfers, or any cycle with `hsel`=0 or `hready`=0, change no register and raise no pulse.
- R3: Write data is taken from `hwdata` in the cycle after the address phase; read data is driven on `hrdata` in the cycle after the address phase and `hrdata` is 0 in every cycle that is not a read data phase.
- R4: The frame base register (offset 0x4) holds all 32 bits written, resets to 0, reads back as written and drives `frameBase`.
- R5: The threshold register (offset 0x8) keeps only bits 10:0 of the written word, resets to 0, reads back with bits 31:11 as 0 and drives `threshold`.
- R6: A command write (offset 0x0) with bit 0 = 1 and bit 1 = 0 while idle raises `scanStart` for exactly one cycle, in the cycle after the data phase, and sets status bit 0 (busy); the command register always reads as 0.
- R7: A start command written while busy is ignored: no `scanStart` pulse and busy stays 1.
- R8: A command write with bit 1 = 1 raises `scanStop` for one cycle in the cycle after the data phase and clears busy; when bits 0 and 1 are both 1 the stop is taken and the start is dropped.
- R9: A `scanDone` pulse clears busy and sets status bit 1 (done), which stays set afterwards.
- R10: A status write (offset 0xC) with bit 1 = 1 clears done, one with bit 1 = 0 leaves it alone, and a `scanDone` in the same cycle as the clearing write keeps done set.
- R11: Offsets 0x10 to 0x3C and any address with a bit above bit 3 set read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 for write, 0 for read |
| hwdata | input | 32 | Write data (data phase) |
| hready | input | 1 | Bus ready, previous transfer complete |
| hrdata | output | 32 | Read data (data phase) |
| hreadyout | output | 1 | Slave ready, tied high |
| hresp | output | 1 | Response, always OKAY |
| scanStart | output | 1 | One-cycle start pulse to the engine |
| scanStop | output | 1 | One-cycle stop pulse to the engine |
| scanDone | input | 1 | One-cycle completion pulse from the engine |
| frameBase | output | 32 | Frame start address in memory |
| threshold | output | 11 | Gradient threshold |

## Verification
The bench goes after the address/data phase split: a design that latched data in the address phase, or that acted on IDLE, BUSY, unselected or not-ready cycles, would corrupt the base register during the sweeps of those cases. It sweeps every unmapped word offset and an aliasing high address, where a decoder that ignored the upper bits would overwrite the frame base or return non-zero data. It drives the command corner cases, a second start while busy, stop and start together, and a completion arriving in the same cycle as the clearing write; a design with the wrong priority would emit a spurious start pulse, keep busy set or lose the done flag.

// File: rtl/edge_ctrl_pkg.sv
package edge_ctrl_pkg;
  localparam int unsigned IDX_W = 2;

  typedef enum logic [IDX_W-1:0] {
    IDX_CMD    = 2'd0,
    IDX_BASE   = 2'd1,
    IDX_THRESH = 2'd2,
    IDX_STATUS = 2'd3
  } reg_idx_t;

  // strobes from bus control to the register datapath
  typedef struct packed {
    logic     wrCmd;
    logic     wrBase;
    logic     wrThresh;
    logic     wrStatus;
    logic     rdEn;
    reg_idx_t rdSel;
  } ctrl_strobe_t;
endpackage

// File: rtl/edge_ctrl_bus.sv
module edge_ctrl_bus
  import edge_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic              hready,
  output ctrl_strobe_t      strobe
);
  localparam int unsigned LOW_W = IDX_W + 2;

  logic     pendValid;
  logic     pendWrite;
  logic     pendMapped;
  reg_idx_t pendIdx;
  logic     accept;
  logic     doWr;

  assign accept = hsel && hready && htrans[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid  <= 1'b0;
      pendWrite  <= 1'b0;
      pendMapped <= 1'b0;
      pendIdx    <= IDX_CMD;
    end else begin
      pendValid <= accept;
      if (accept) begin
        pendWrite  <= hwrite;
        pendMapped <= (haddr[ADDR_W-1:LOW_W] == '0);
        pendIdx    <= reg_idx_t'(haddr[LOW_W-1:2]);
      end
    end
  end

  assign doWr = pendValid && pendWrite && pendMapped;

  always_comb begin
    strobe.wrCmd    = doWr && (pendIdx == IDX_CMD);
    strobe.wrBase   = doWr && (pendIdx == IDX_BASE);
    strobe.wrThresh = doWr && (pendIdx == IDX_THRESH);
    strobe.wrStatus = doWr && (pendIdx == IDX_STATUS);
    strobe.rdEn     = pendValid && !pendWrite && pendMapped;
    strobe.rdSel    = pendIdx;
  end
endmodule

// File: rtl/edge_ctrl_regs.sv
module edge_ctrl_regs
  import edge_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned THRESH_W = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strobe,
  input  logic [DATA_W-1:0]   hwdata,
  input  logic                scanDone,
  output logic [DATA_W-1:0]   hrdata,
  output logic                scanStart,
  output logic                scanStop,
  output logic [DATA_W-1:0]   frameBase,
  output logic [THRESH_W-1:0] threshold,
  output logic                busy,
  output logic                done
);
  localparam int unsigned START_BIT = 0;
  localparam int unsigned STOP_BIT  = 1;
  localparam int unsigned BUSY_BIT  = 0;
  localparam int unsigned DONE_BIT  = 1;

  logic startReq;
  logic stopReq;
  logic clearReq;

  assign stopReq  = strobe.wrCmd && hwdata[STOP_BIT];
  assign startReq = strobe.wrCmd && hwdata[START_BIT] && !hwdata[STOP_BIT] && !busy;
  assign clearReq = strobe.wrStatus && hwdata[DONE_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameBase <= '0;
      threshold <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      scanStart <= 1'b0;
      scanStop  <= 1'b0;
    end else begin
      if (strobe.wrBase)   frameBase <= hwdata;
      if (strobe.wrThresh) threshold <= hwdata[THRESH_W-1:0];
      scanStart <= startReq;
      scanStop  <= stopReq;
      if (stopReq)        busy <= 1'b0;
      else if (startReq)  busy <= 1'b1;
      else if (scanDone)  busy <= 1'b0;
      if (scanDone)       done <= 1'b1;
      else if (clearReq)  done <= 1'b0;
    end
  end

  always_comb begin
    hrdata = '0;
    if (strobe.rdEn) begin
      unique case (strobe.rdSel)
        IDX_BASE:   hrdata = frameBase;
        IDX_THRESH: hrdata[THRESH_W-1:0] = threshold;
        IDX_STATUS: begin
          hrdata[BUSY_BIT] = busy;
          hrdata[DONE_BIT] = done;
        end
        default:    hrdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/edge_ctrl_slave.sv
module edge_ctrl_slave
  import edge_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned THRESH_W = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hsel,
  input  logic [ADDR_W-1:0]   haddr,
  input  logic [1:0]          htrans,
  input  logic                hwrite,
  input  logic [DATA_W-1:0]   hwdata,
  input  logic                hready,
  output logic [DATA_W-1:0]   hrdata,
  output logic                hreadyout,
  output logic                hresp,
  output logic                scanStart,
  output logic                scanStop,
  input  logic                scanDone,
  output logic [DATA_W-1:0]   frameBase,
  output logic [THRESH_W-1:0] threshold
);
  ctrl_strobe_t strobe;
  logic         busyQ;
  logic         doneQ;

  assign hreadyout = 1'b1;
  assign hresp     = 1'b0;

  edge_ctrl_bus #(.ADDR_W(ADDR_W)) bus_i (
    .clk(clk), .rstN(rstN), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hready(hready), .strobe(strobe)
  );

  edge_ctrl_regs #(.DATA_W(DATA_W), .THRESH_W(THRESH_W)) regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hwdata(hwdata),
    .scanDone(scanDone), .hrdata(hrdata), .scanStart(scanStart),
    .scanStop(scanStop), .frameBase(frameBase), .threshold(threshold),
    .busy(busyQ), .done(doneQ)
  );
endmodule

// File: rtl/edge_ctrl_chk.sv
module edge_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hsel,
  input logic       hready,
  input logic [1:0] htrans,
  input logic       hwrite,
  input logic       hreadyout,
  input logic       hresp,
  input logic       scanStart,
  input logic       scanStop,
  input logic       scanDone,
  input logic       busy,
  input logic       done
);
  logic wrAccept;
  assign wrAccept = hsel && hready && htrans[1] && hwrite;

  assert_okay_R1: assert property (@(posedge clk) disable iff (!rstN)
    hreadyout && !hresp);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (scanStart || scanStop || $fell(done)) |-> $past(wrAccept, 2));

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    scanStart |-> (busy && !$past(scanStart)));

  assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    scanStart |-> !$past(busy));

  assert_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    scanStop |-> (!busy && !scanStart));

  assert_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> done);

  assert_busy_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(scanDone) && !scanStart) |-> !busy);
endmodule

bind edge_ctrl_slave edge_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .hsel(hsel), .hready(hready), .htrans(htrans),
  .hwrite(hwrite), .hreadyout(hreadyout), .hresp(hresp),
  .scanStart(scanStart), .scanStop(scanStop), .scanDone(scanDone),
  .busy(busyQ), .done(doneQ)
);

// File: tb/edge_ctrl_slave_tb.sv
module edge_ctrl_slave_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hsel = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [31:0] hwdata = '0;
  logic        hready = 1'b1;
  logic [31:0] hrdata;
  logic        hreadyout;
  logic        hresp;
  logic        scanStart;
  logic        scanStop;
  logic        scanDone = 1'b0;
  logic [31:0] frameBase;
  logic [10:0] threshold;

  int errors = 0;
  int checks = 0;
  logic doneInData = 1'b0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_ctrl_slave dut_i (
    .clk(clk), .rstN(rstN), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hwdata(hwdata), .hready(hready), .hrdata(hrdata),
    .hreadyout(hreadyout), .hresp(hresp), .scanStart(scanStart),
    .scanStop(scanStop), .scanDone(scanDone), .frameBase(frameBase),
    .threshold(threshold)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one transfer; returns at the negedge after the data-phase edge
  task automatic xfer(input logic [31:0] a, input logic wr, input logic [31:0] wd,
                      input logic sel, input logic [1:0] tr, input logic rdy,
                      output logic [31:0] rdata);
    @(negedge clk);
    hsel = sel; haddr = a; htrans = tr; hwrite = wr; hready = rdy;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hready = 1'b1; haddr = '0;
    hwdata = wd; scanDone = doneInData;
    rdata = hrdata;
    @(negedge clk);
    scanDone = 1'b0; hwdata = '0;
  endtask

  task automatic wr32(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    xfer(a, 1'b1, d, 1'b1, 2'b10, 1'b1, dummy);
  endtask

  task automatic rd32(input logic [31:0] a, output logic [31:0] d);
    xfer(a, 1'b0, '0, 1'b1, 2'b10, 1'b1, d);
  endtask

  task automatic pulseDone();
    @(negedge clk); scanDone = 1'b1;
    @(negedge clk); scanDone = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // reset state
    check("R1 hreadyout", {31'd0, hreadyout}, 32'd1);
    check("R1 hresp", {31'd0, hresp}, 32'd0);
    check("R6 reset scanStart", {31'd0, scanStart}, 32'd0);
    rd32(32'h4, rd); check("R4 reset base", rd, 32'd0);
    rd32(32'h8, rd); check("R5 reset thresh", rd, 32'd0);
    rd32(32'hC, rd); check("R9 reset status", rd, 32'd0);

    // base register patterns, including NONSEQ and SEQ types
    for (int i = 0; i < 32; i++) begin
      logic [31:0] pat;
      pat = (32'h1 << i) ^ (32'h9E37_79B9 * (i + 1));
      xfer(32'h4, 1'b1, pat, 1'b1, (i % 2 == 0) ? 2'b10 : 2'b11, 1'b1, rd);
      check("R4 frameBase out", frameBase, pat);
      rd32(32'h4, rd); check("R4 base readback", rd, pat);
      @(negedge clk); check("R3 hrdata idle zero", hrdata, 32'd0);
    end
    // threshold sweep
    for (int i = 0; i < 24; i++) begin
      logic [31:0] pat;
      pat = 32'hFFFF_F800 | (32'd89 * i);
      if (i == 23) pat = 32'hFFFF_FFFF;
      wr32(32'h8, pat);
      check("R5 threshold out", {21'd0, threshold}, {21'd0, pat[10:0]});
      rd32(32'h8, rd); check("R5 thresh readback", rd, {21'd0, pat[10:0]});
    end

    // ignored transfer kinds
    wr32(32'h4, 32'hA5A5_0001);
    for (int k = 0; k < 4; k++) begin
      logic sel; logic [1:0] tr; logic rdy;
      sel = 1'b1; tr = 2'b10; rdy = 1'b1;
      if (k == 0) tr = 2'b00;
      if (k == 1) tr = 2'b01;
      if (k == 2) sel = 1'b0;
      if (k == 3) rdy = 1'b0;
      xfer(32'h4, 1'b1, 32'h0BAD_0000 + k, sel, tr, rdy, rd);
      check("R2 ignored write base", frameBase, 32'hA5A5_0001);
      xfer(32'h0, 1'b1, 32'h1, sel, tr, rdy, rd);
      check("R2 ignored start", {31'd0, scanStart}, 32'd0);
      rd32(32'hC, rd); check("R2 status unchanged", rd, 32'd0);
    end

    // unmapped offsets and aliasing high addresses
    for (int o = 4; o < 16; o++) begin
      wr32(o * 4, 32'hDEAD_0000 + o);
      rd32(o * 4, rd); check("R11 unmapped read", rd, 32'd0);
      check("R11 base untouched", frameBase, 32'hA5A5_0001);
    end
    wr32(32'h0000_0104, 32'h1234_5678);
    check("R11 alias write ignored", frameBase, 32'hA5A5_0001);
    rd32(32'h8000_0004, rd); check("R11 alias read zero", rd, 32'd0);
    wr32(32'h0000_0100, 32'h1);
    check("R11 alias start ignored", {31'd0, scanStart}, 32'd0);

    // start / busy / stop
    wr32(32'h0, 32'h1);
    check("R6 start pulse", {31'd0, scanStart}, 32'd1);
    @(negedge clk); check("R6 start one cycle", {31'd0, scanStart}, 32'd0);
    rd32(32'hC, rd); check("R6 busy set", rd, 32'd1);
    rd32(32'h0, rd); check("R6 command reads zero", rd, 32'd0);
    wr32(32'h0, 32'h1);
    check("R7 start while busy", {31'd0, scanStart}, 32'd0);
    rd32(32'hC, rd); check("R7 still busy", rd, 32'd1);
    wr32(32'h0, 32'h2);
    check("R8 stop pulse", {31'd0, scanStop}, 32'd1);
    @(negedge clk); check("R8 stop one cycle", {31'd0, scanStop}, 32'd0);
    rd32(32'hC, rd); check("R8 busy cleared", rd, 32'd0);
    wr32(32'h0, 32'h3);
    check("R8 both: stop", {31'd0, scanStop}, 32'd1);
    check("R8 both: no start", {31'd0, scanStart}, 32'd0);
    rd32(32'hC, rd); check("R8 both: idle", rd, 32'd0);

    // completion
    wr32(32'h0, 32'h1);
    pulseDone();
    rd32(32'hC, rd); check("R9 done set busy clear", rd, 32'd2);
    repeat (5) @(negedge clk);
    rd32(32'hC, rd); check("R9 done sticky", rd, 32'd2);
    wr32(32'hC, 32'h1);
    rd32(32'hC, rd); check("R10 write 0 keeps done", rd, 32'd2);
    wr32(32'hC, 32'h2);
    rd32(32'hC, rd); check("R10 clear done", rd, 32'd0);
    pulseDone();
    doneInData = 1'b1;
    wr32(32'hC, 32'h2);
    doneInData = 1'b0;
    rd32(32'hC, rd); check("R10 done wins over clear", rd, 32'd2);
    wr32(32'h0, 32'h1);
    check("R6 restart after done", {31'd0, scanStart}, 32'd1);
    rd32(32'hC, rd); check("R9 busy with done", rd, 32'd3);
    check("R1 hreadyout end", {31'd0, hreadyout}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule